// File: doc/BRIEF.md
# Partial-Bank Address Remapping Stage

This stage sits in front of a memory address decoder in systems where only part of the bank set is populated. It accepts a 40-bit physical address with a shift amount and a 4-bit bank-set code. When the shift is 1 or 2, the bits above position 8 are moved up by that amount. Bits 8 and 7 are then rebuilt from a seed value and a per-code override table. Bit 6 and the six lowest bits are copied through. When the shift is 0, the address passes unchanged.

The result is registered once. A valid bit travels alongside it, so a request presented on one clock edge is available on the next. The two rebuilt bits are also given on a separate bank-select output. A shift amount of 3 has no defined remapping: the address passes through untouched, and an error flag is raised on that output cycle only.

Top module: `pbank_remap`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_shift_err are 0 after that edge.
- R2: out_valid equals the value in_valid had at the previous clock edge. out_addr, out_bank_sel and out_shift_err are loaded only from a request with in_valid high, and out_addr and out_bank_sel hold their values while in_valid is low.
- R3: With in_shift = 0, out_addr equals in_addr whatever in_mask is.
- R4: For every shift amount, out_addr[6:0] equals in_addr[6:0].
- R5: With in_shift = 1, out_addr[39:9] equals in_addr[38:8], and bits 8 and 7 both start from in_addr[7] before the code override of R7.
- R6: With in_shift = 2, out_addr[39:9] equals in_addr[37:7], and bits 8 and 7 both start from 0 before the code override of R7.
- R7: With in_shift of 1 or 2, in_mask applies these overrides to the seeded bits: code 2 sets bit 7; code 3 clears bit 8; code 4 sets bit 8; code 5 clears bit 7; code 6 inverts bit 7; code 8 sets both bits; code 10 sets bit 7; code 12 sets bit 8.
- R8: Codes 0, 1, 7, 9, 11, 13, 14 and 15 leave both seeded bits unchanged.
- R9: out_bank_sel always equals out_addr[8:7].
- R10: With in_shift = 3, out_addr equals in_addr and out_shift_err is 1 in the cycle that result is valid. out_shift_err is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 40 | Physical address to remap |
| in_shift | input | 2 | Shift amount; 0 to 2 defined, 3 flagged |
| in_mask | input | 4 | Bank-set code that selects the bit 8:7 override |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 40 | Remapped address |
| out_bank_sel | output | 2 | Bank-set select, equal to out_addr[8:7] |
| out_shift_err | output | 1 | Request had an undefined shift amount |

## Verification
All four outputs are due exactly one rising edge after the request is presented. Each scenario task drives its request on a falling edge, waits for the next falling edge, and samples all outputs there, half a period after the edge that loaded them. For the hold and error-clearing checks, the task then drives an idle cycle carrying different input values and samples again one falling edge later. The mask table is swept over all sixteen codes for both defined shift amounts. The directed cases set the seed bit to both values, so that inversion and forcing are distinguished from pass-through.

// File: rtl/pbr_pkg.sv
// Package pbr_pkg
// Shared constants for the partial-bank remapping stage: field widths,
// the positions of the rebuilt bits, and the bank-set override codes.
// Assumes a single address width is used across the whole stage.
package pbr_pkg;

    localparam int PA_W       = 40;  // physical address width
    localparam int SHIFT_W    = 2;   // shift amount field width
    localparam int MASK_W     = 4;   // bank-set code width
    localparam int MAX_SHIFT  = 2;   // largest defined shift amount
    localparam int KEEP_LSB_W = 7;   // bits [6:0] always copied through
    localparam int SEL_LSB    = 7;   // lower rebuilt bit
    localparam int HI_LSB     = 9;   // first bit taken from the shifted address
    localparam int SEL_W      = HI_LSB - SEL_LSB;

    // Override codes applied to the seeded bits 8:7
    localparam logic [MASK_W-1:0] CODE_SET_LO     = 4'h2;
    localparam logic [MASK_W-1:0] CODE_CLR_HI     = 4'h3;
    localparam logic [MASK_W-1:0] CODE_SET_HI     = 4'h4;
    localparam logic [MASK_W-1:0] CODE_CLR_LO     = 4'h5;
    localparam logic [MASK_W-1:0] CODE_FLIP_LO    = 4'h6;
    localparam logic [MASK_W-1:0] CODE_SET_BOTH   = 4'h8;
    localparam logic [MASK_W-1:0] CODE_SET_LO_ALT = 4'hA;
    localparam logic [MASK_W-1:0] CODE_SET_HI_ALT = 4'hC;

    // Pair of rebuilt bank-set bits
    typedef struct packed {
        logic hi;   // bit 8
        logic lo;   // bit 7
    } sel_pair_t;

endpackage

// File: rtl/pbr_seed.sv
// Module pbr_seed
// Produces the starting values of rebuilt bits 8:7 before any override.
// Shift 1 copies the address bit at SEL_LSB into both bits. Any larger
// shift seeds both with zero. Assumes the caller only uses the result when
// the effective shift is nonzero.
module pbr_seed
    import pbr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int SH_W   = SHIFT_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SH_W-1:0]   shift_i,
    output sel_pair_t         seed_o
);

    localparam logic [SH_W-1:0] ONE = SH_W'(1);

    // Select the seed from the shift amount
    always_comb begin
        if (shift_i == ONE) begin
            seed_o.hi = addr_i[SEL_LSB];
            seed_o.lo = addr_i[SEL_LSB];
        end else begin
            seed_o.hi = 1'b0;
            seed_o.lo = 1'b0;
        end
    end

endmodule

// File: rtl/pbr_override.sv
// Module pbr_override
// Applies the bank-set code table to the seeded bits 8:7. Codes that are
// absent from the table pass the seed through unchanged. This module is
// purely combinational and independent of the shift amount.
module pbr_override
    import pbr_pkg::*;
#(
    parameter int CODE_W = MASK_W
) (
    input  sel_pair_t         seed_i,
    input  logic [CODE_W-1:0] code_i,
    output sel_pair_t         sel_o
);

    // Look up the override for the given code
    always_comb begin
        sel_o = seed_i;
        case (code_i)
            CODE_SET_LO:     sel_o.lo = 1'b1;
            CODE_CLR_HI:     sel_o.hi = 1'b0;
            CODE_SET_HI:     sel_o.hi = 1'b1;
            CODE_CLR_LO:     sel_o.lo = 1'b0;
            CODE_FLIP_LO:    sel_o.lo = ~seed_i.lo;
            CODE_SET_BOTH: begin
                sel_o.hi = 1'b1;
                sel_o.lo = 1'b1;
            end
            CODE_SET_LO_ALT: sel_o.lo = 1'b1;
            CODE_SET_HI_ALT: sel_o.hi = 1'b1;
            default:         sel_o = seed_i;
        endcase
    end

endmodule

// File: rtl/pbr_upper.sv
// Module pbr_upper
// Builds the address bits from HI_LSB upward by selecting, per bit, the
// input bit that lies shift_i places lower. Assumes shift_i never exceeds
// MAX_AMT. Out-of-range amounts select zero, and the top-level guard keeps
// them from reaching this module.
module pbr_upper
    import pbr_pkg::*;
#(
    parameter int ADDR_W  = PA_W,
    parameter int SH_W    = SHIFT_W,
    parameter int MAX_AMT = MAX_SHIFT,
    parameter int LSB     = HI_LSB
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [SH_W-1:0]       shift_i,
    output logic [ADDR_W-LSB-1:0] hi_o
);

    localparam int N_AMT = 1 << SH_W;

    // One selector per output bit
    for (genvar i = LSB; i < ADDR_W; i++) begin : g_bit
        logic [N_AMT-1:0] cand;
        for (genvar k = 0; k < N_AMT; k++) begin : g_amt
            if (k <= MAX_AMT && i - k >= 0) begin : g_src
                assign cand[k] = addr_i[i-k];
            end else begin : g_zero
                assign cand[k] = 1'b0;
            end
        end
        assign hi_o[i-LSB] = cand[shift_i];
    end

endmodule

// File: rtl/pbank_remap.sv
// Module pbank_remap
// Single registered stage that remaps a physical address for partially
// populated bank sets. It shifts the upper bits, rebuilds bits 8:7 from the
// seed and the override code, and copies bits 6:0 through. A shift of 0
// passes the address through. A shift above MAX_SHIFT also passes through
// and flags an error for that output cycle only. Synchronous, active-low reset.
module pbank_remap
    import pbr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int SH_W   = SHIFT_W,
    parameter int CODE_W = MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SH_W-1:0]   in_shift,
    input  logic [CODE_W-1:0] in_mask,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SEL_W-1:0]  out_bank_sel,
    output logic              out_shift_err
);

    localparam int HI_W = ADDR_W - HI_LSB;
    localparam logic [SH_W-1:0] MAX_AMT_V = SH_W'(MAX_SHIFT);

    logic              bad_shift;
    logic [SH_W-1:0]   eff_shift;
    sel_pair_t         seed;
    sel_pair_t         sel;
    logic [HI_W-1:0]   hi_bits;
    logic [ADDR_W-1:0] next_addr;

    logic              vld_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;

    // Reduce undefined shift amounts to pass-through
    always_comb begin
        bad_shift = (in_shift > MAX_AMT_V);
        eff_shift = bad_shift ? '0 : in_shift;
    end

    pbr_seed #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_seed (
        .addr_i  (in_addr),
        .shift_i (eff_shift),
        .seed_o  (seed)
    );

    pbr_override #(.CODE_W(CODE_W)) u_ovr (
        .seed_i (seed),
        .code_i (in_mask),
        .sel_o  (sel)
    );

    pbr_upper #(
        .ADDR_W  (ADDR_W),
        .SH_W    (SH_W),
        .MAX_AMT (MAX_SHIFT),
        .LSB     (HI_LSB)
    ) u_upper (
        .addr_i  (in_addr),
        .shift_i (eff_shift),
        .hi_o    (hi_bits)
    );

    // Assemble the remapped address, or pass through when no shift applies
    always_comb begin
        if (eff_shift == '0) begin
            next_addr = in_addr;
        end else begin
            next_addr = {hi_bits, sel.hi, sel.lo, in_addr[KEEP_LSB_W-1:0]};
        end
    end

    // Valid and error flags: cleared by reset, error lives one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            err_q <= in_valid & bad_shift;
        end
    end

    // Result register loads only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (in_valid) begin
            addr_q <= next_addr;
        end
    end

    assign out_valid     = vld_q;
    assign out_shift_err = err_q;
    assign out_addr      = addr_q;
    assign out_bank_sel  = addr_q[HI_LSB-1:SEL_LSB];

endmodule

// File: rtl/pbank_remap_chk.sv
// Module pbank_remap_chk
// Port-level properties of pbank_remap, bound to every instance of it.
module pbank_remap_chk
    import pbr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int SH_W   = SHIFT_W,
    parameter int CODE_W = MASK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic [SH_W-1:0]   in_shift,
    input logic [CODE_W-1:0] in_mask,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [SEL_W-1:0]  out_bank_sel,
    input logic              out_shift_err
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

    p_pass_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shift == '0) |=> out_addr == $past(in_addr));

    p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_addr[KEEP_LSB_W-1:0] == $past(in_addr[KEEP_LSB_W-1:0]));

    p_sel_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_bank_sel == out_addr[HI_LSB-1:SEL_LSB]);

    p_bad_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shift == '1) |=> (out_shift_err && out_addr == $past(in_addr)));

    p_err_only_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_shift_err |-> out_valid);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_shift_err));

endmodule

bind pbank_remap pbank_remap_chk #(
    .ADDR_W (ADDR_W),
    .SH_W   (SH_W),
    .CODE_W (CODE_W)
) u_chk (.*);

// File: tb/tb_pbank_remap.sv
`timescale 1ns/1ps
module tb_pbank_remap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] in_addr = '0;
    logic [1:0]  in_shift = '0;
    logic [3:0]  in_mask = '0;
    logic        out_valid;
    logic [39:0] out_addr;
    logic [1:0]  out_bank_sel;
    logic        out_shift_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pbank_remap dut (
        .clk, .rst_n, .in_valid, .in_addr, .in_shift, .in_mask,
        .out_valid, .out_addr, .out_bank_sel, .out_shift_err
    );

    // Expected result from the requirements (R3..R8, R10)
    function automatic logic [39:0] expect_addr(logic [39:0] a, logic [1:0] s, logic [3:0] m);
        logic [39:0] up;
        logic b7, b8;
        if (s == 2'd0 || s == 2'd3) return a;
        up = a << s;
        b7 = (s == 2'd1) ? a[7] : 1'b0;
        b8 = b7;
        case (m)
            4'h2, 4'hA: b7 = 1'b1;
            4'h3:       b8 = 1'b0;
            4'h4, 4'hC: b8 = 1'b1;
            4'h5:       b7 = 1'b0;
            4'h6:       b7 = ~b7;
            4'h8: begin b7 = 1'b1; b8 = 1'b1; end
            default: ;
        endcase
        return {up[39:9], b8, b7, a[6:0]};
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one request, sample its result one edge later
    task automatic apply(string req, logic [39:0] a, logic [1:0] s, logic [3:0] m);
        logic [39:0] e;
        e = expect_addr(a, s, m);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_shift = s; in_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "addr", 64'(out_addr), 64'(e));
        check("R9", "bank_sel", 64'(out_bank_sel), 64'(e[8:7]));
        check("R2", "valid", 64'(out_valid), 64'd1);
        check("R10", "err", 64'(out_shift_err), 64'(s == 2'd3));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b1; in_shift = 2'd3;
        repeat (2) @(negedge clk);
        check("R1", "valid in reset", 64'(out_valid), 64'd0);
        check("R1", "err in reset", 64'(out_shift_err), 64'd0);
        rst_n = 1'b1; in_valid = 1'b0; in_shift = 2'd0;
        @(negedge clk);
    endtask

    task automatic t_pass_zero;
        apply("R3", 40'hA5_5A5A_5A5A, 2'd0, 4'h8);
        apply("R3", 40'hFF_FFFF_FFFF, 2'd0, 4'h6);
        apply("R3", 40'h00_0000_0180, 2'd0, 4'h3);
    endtask

    task automatic t_shift_one;
        apply("R5", 40'h12_3456_789A, 2'd1, 4'h0);
        apply("R5", 40'h7F_FFFF_FF80, 2'd1, 4'h9);   // seed 1 into both
        apply("R5", 40'h80_0000_0100, 2'd1, 4'h1);   // top bit dropped
        apply("R7", 40'h00_0000_0080, 2'd1, 4'h6);   // flip: lo 0, hi 1
        apply("R4", 40'h00_0000_007F, 2'd1, 4'h5);
    endtask

    task automatic t_shift_two;
        apply("R6", 40'h3F_0F0F_0FFF, 2'd2, 4'h0);
        apply("R6", 40'hC0_0000_0080, 2'd2, 4'hF);
        apply("R7", 40'h00_0000_0000, 2'd2, 4'h6);   // flip zero seed
        apply("R4", 40'h00_0000_0055, 2'd2, 4'h8);
    endtask

    task automatic t_code_sweep;
        for (int s = 1; s <= 2; s++) begin
            for (int m = 0; m < 16; m++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [39:0] a;
                    a = (k == 0) ? 40'h5C_3A91_E2D7 : 40'h23_C56E_1D28;
                    apply((m == 0 || m == 1 || m == 7 || m == 9 || m == 11 ||
                           m >= 13) ? "R8" : "R7", a, 2'(s), 4'(m));
                end
            end
        end
    endtask

    task automatic t_bad_shift;
        apply("R10", 40'h9E_8D7C_6B5A, 2'd3, 4'h8);
        // following idle cycle: error gone, output held
        @(negedge clk);
        in_addr = 40'h11_1111_1111; in_shift = 2'd3;
        @(negedge clk);
        check("R10", "err after", 64'(out_shift_err), 64'd0);
        check("R2", "valid idle", 64'(out_valid), 64'd0);
        check("R2", "hold", 64'(out_addr), 64'h9E_8D7C_6B5A);
        in_shift = 2'd0;
    endtask

    task automatic t_hold;
        apply("R2", 40'h01_2345_6789, 2'd1, 4'h4);
        @(negedge clk);
        in_addr = 40'hFE_DCBA_9876; in_shift = 2'd2; in_mask = 4'h8;
        repeat (2) @(negedge clk);
        check("R2", "hold addr", 64'(out_addr), 64'(expect_addr(40'h01_2345_6789, 2'd1, 4'h4)));
        check("R2", "valid low", 64'(out_valid), 64'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; in_addr = 40'h0F_0000_0080; in_shift = 2'd1; in_mask = 4'h0;
        @(negedge clk);
        check("R5", "b2b first", 64'(out_addr), 64'(expect_addr(40'h0F_0000_0080, 2'd1, 4'h0)));
        in_addr = 40'h0F_0000_0080; in_shift = 2'd2; in_mask = 4'hC;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6", "b2b second", 64'(out_addr), 64'(expect_addr(40'h0F_0000_0080, 2'd2, 4'hC)));
        check("R2", "b2b valid", 64'(out_valid), 64'd1);
    endtask

    initial begin
        t_reset();
        t_pass_zero();
        t_shift_one();
        t_shift_two();
        t_code_sweep();
        t_bad_shift();
        t_hold();
        t_back_to_back();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule